// File: doc/BRIEF.md
# Ethernet MAC Statistics Counter Bank

This block keeps the receive and transmit statistics of one Ethernet MAC port. The MAC datapath sends one status event per finished frame on each direction. The event carries the frame length, the address class and a small set of condition flags. The block turns each event into increments of frame and byte totals, class counts, per-condition counts and a seven-bucket length histogram.

Software reads the counters through a simple read port. Each read clears the counter it reads. A single control input clears every counter at once. Byte totals are wider than a word and are read as two words with an atomic latch. The counters stop at their maximum value and do not wrap. A separate counter tracks frames above the programmed maximum packet size; the top bit of its read word shows the current receive FIFO empty state.

Top module: `eth_stat_counters`

## Requirements
- R1: After reset every counter is zero, and reading any counter address returns 0.
- R2: `rd_data_o` carries the addressed value in the cycle after `rd_en_i` is sampled high, and holds between reads. The counter index equals the read address. Receive: 0 frames, 1 bytes low, 2 multicast, 3 broadcast, 4 pause, 5 FCS error, 6 symbol error, 7 short, 8 jabber, 9 oversize, 10 max-size error, 11..17 length buckets. Transmit: 18 frames, 19 bytes low, 20 multicast, 21 broadcast, 22 pause, 23 bad frame, 24..30 length buckets.
- R3: A read returns the value before that cycle and clears the counter. If an increment of the same counter falls in the read cycle, the counter's new value is that increment, so the event is kept.
- R4: `clear_all_i` zeroes all counters in the next cycle. An event in the same cycle as the clear is counted on top of zero.
- R5: Each valid event adds 1 to the frame counter of its direction and adds its length to the byte counter of that direction.
- R6: Class code 2'b01 counts as multicast and 2'b10 counts as broadcast. Codes 2'b00 and 2'b11 touch neither counter.
- R7: Receive flag bits map as follows: bit0 pause, bit1 FCS error, bit2 symbol error, bit3 short, bit4 jabber, bit5 oversize, bit6 above maximum packet size. Each set bit adds 1 to its counter.
- R8: Transmit flag bit0 counts pause frames. Bit1 counts any bad frame (underrun, bad FCS or another error) in a single counter.
- R9: Every event adds 1 to exactly one bucket of its direction. Lengths up to 64 go to bucket 0, 65..127 to 1, 128..255 to 2, 256..511 to 3, 512..1023 to 4, 1024..1518 to 5, and 1519 or more to 6.
- R10: Reading address 10 returns `rx_fifo_empty_i` in bit 31. The max-size count is FRAME_W-1 bits wide, sits below bit 31 and is not affected by that bit.
- R11: Byte counters are BYTE_W bits wide (45 by default). Reading the low word (address 1 or 19) latches the bits above 31 into a shadow and clears the counter. Address 32 (receive) or 33 (transmit) returns that shadow and does not clear anything.
- R12: A counter that reaches its maximum value stays there on further increments instead of wrapping.
- R13: Addresses 31 and 34..63 read as 0 and clear no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_all_i | input | 1 | Clear every counter |
| rx_valid_i | input | 1 | Receive status event valid |
| rx_len_i | input | LEN_W | Receive frame length in bytes |
| rx_cls_i | input | 2 | Receive address class |
| rx_flags_i | input | 7 | Receive condition flags |
| rx_fifo_empty_i | input | 1 | Receive FIFO empty state |
| tx_valid_i | input | 1 | Transmit status event valid |
| tx_len_i | input | LEN_W | Transmit frame length in bytes |
| tx_cls_i | input | 2 | Transmit address class |
| tx_flags_i | input | 2 | Transmit condition flags |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 6 | Read address |
| rd_data_o | output | 32 | Read data, one cycle after the strobe |

## Verification
The assertions check several rules on every cycle. The global clear must empty the whole bank when no event competes with it. The receive frame count must never fall without a clear, and must step by exactly one per event. A read that collides with a transmit event must leave the count at one. Each event must pick exactly one length bucket. The empty flag must appear in the read word, and unmapped reads must return zero. Only the bench scenarios can show the rest: the bucket edges, the class and flag mapping, the high-word latch after the byte total crosses 2^32, and saturation of both the frame and the byte counters. Each of these needs a chosen sequence of events followed by reads.

// File: rtl/eth_stat_pkg.sv
package eth_stat_pkg;
  localparam int NCNT   = 31;
  localparam int NBKT   = 7;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;

  localparam int C_RX_FRM   = 0;
  localparam int C_RX_BYT   = 1;
  localparam int C_RX_MC    = 2;
  localparam int C_RX_BC    = 3;
  localparam int C_RX_FLAG  = 4;   // 7 flag counters, pause first
  localparam int C_RX_MAXSZ = 10;
  localparam int C_RX_BKT   = 11;
  localparam int C_TX_FRM   = 18;
  localparam int C_TX_BYT   = 19;
  localparam int C_TX_MC    = 20;
  localparam int C_TX_BC    = 21;
  localparam int C_TX_FLAG  = 22;  // pause, bad
  localparam int C_TX_BKT   = 24;

  localparam int A_RX_BYT_HI = 32;
  localparam int A_TX_BYT_HI = 33;

  localparam int N_RX_FLAG = 7;
  localparam int N_TX_FLAG = 2;

  typedef enum logic [1:0] {
    CLS_UNI  = 2'b00,
    CLS_MULT = 2'b01,
    CLS_BRD  = 2'b10,
    CLS_RSV  = 2'b11
  } addr_cls_e;

  function automatic logic [2:0] bucket_of(input logic [31:0] len);
    if (len <= 32'd64)        return 3'd0;
    else if (len <= 32'd127)  return 3'd1;
    else if (len <= 32'd255)  return 3'd2;
    else if (len <= 32'd511)  return 3'd3;
    else if (len <= 32'd1023) return 3'd4;
    else if (len <= 32'd1518) return 3'd5;
    else                      return 3'd6;
  endfunction
endpackage

// File: rtl/stat_evt_dec.sv
module stat_evt_dec
  import eth_stat_pkg::*;
#(
  parameter int LEN_W = 14
) (
  input  logic                 rx_valid_i,
  input  logic [LEN_W-1:0]     rx_len_i,
  input  logic [1:0]           rx_cls_i,
  input  logic [N_RX_FLAG-1:0] rx_flags_i,
  input  logic                 tx_valid_i,
  input  logic [LEN_W-1:0]     tx_len_i,
  input  logic [1:0]           tx_cls_i,
  input  logic [N_TX_FLAG-1:0] tx_flags_i,
  output logic [NCNT-1:0]      inc_o
);
  logic [2:0] rx_bkt, tx_bkt;

  assign rx_bkt = bucket_of(32'(rx_len_i));
  assign tx_bkt = bucket_of(32'(tx_len_i));

  always_comb begin
    inc_o = '0;
    if (rx_valid_i) begin
      inc_o[C_RX_FRM] = 1'b1;
      inc_o[C_RX_BYT] = 1'b1;
      inc_o[C_RX_MC]  = (rx_cls_i == CLS_MULT);
      inc_o[C_RX_BC]  = (rx_cls_i == CLS_BRD);
      for (int b = 0; b < N_RX_FLAG; b++) inc_o[C_RX_FLAG+b] = rx_flags_i[b];
      inc_o[C_RX_BKT + int'(rx_bkt)] = 1'b1;
    end
    if (tx_valid_i) begin
      inc_o[C_TX_FRM] = 1'b1;
      inc_o[C_TX_BYT] = 1'b1;
      inc_o[C_TX_MC]  = (tx_cls_i == CLS_MULT);
      inc_o[C_TX_BC]  = (tx_cls_i == CLS_BRD);
      for (int b = 0; b < N_TX_FLAG; b++) inc_o[C_TX_FLAG+b] = tx_flags_i[b];
      inc_o[C_TX_BKT + int'(tx_bkt)] = 1'b1;
    end
  end
endmodule

// File: rtl/stat_sat_cnt.sv
module stat_sat_cnt #(
  parameter int W  = 32,
  parameter int AW = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          clr_i,
  input  logic [AW-1:0] amt_i,
  output logic [W-1:0]  val_o
);
  localparam int SW = ((W > AW) ? W : AW) + 1;
  localparam logic [SW-1:0] MAXV = SW'({W{1'b1}});

  logic [W-1:0]  val_q, val_d;
  logic [SW-1:0] base, sum;

  always_comb begin
    // clear first, then add, so a colliding event survives
    base  = clr_i ? '0 : SW'(val_q);
    sum   = base + SW'(amt_i);
    val_d = base[W-1:0];
    if (inc_i) val_d = (sum > MAXV) ? {W{1'b1}} : sum[W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) val_q <= '0;
    else         val_q <= val_d;
  end

  assign val_o = val_q;
endmodule

// File: rtl/stat_rd_port.sv
module stat_rd_port
  import eth_stat_pkg::*;
#(
  parameter int BYTE_W = 45
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         rd_en_i,
  input  logic [ADDR_W-1:0]            rd_addr_i,
  input  logic                         rx_fifo_empty_i,
  input  logic [NCNT-1:0][BYTE_W-1:0]  cnt_i,
  output logic [DATA_W-1:0]            rd_data_o
);
  localparam int HI_W = BYTE_W - 32;

  logic [DATA_W-1:0] sel, data_q;
  logic [HI_W-1:0]   rx_hi_q, tx_hi_q;

  always_comb begin
    sel = '0;
    for (int k = 0; k < NCNT; k++)
      if (rd_addr_i == ADDR_W'(k)) sel = cnt_i[k][31:0];
    if (rd_addr_i == ADDR_W'(C_RX_MAXSZ)) sel[31] = rx_fifo_empty_i;
    if (rd_addr_i == ADDR_W'(A_RX_BYT_HI)) sel = DATA_W'(rx_hi_q);
    if (rd_addr_i == ADDR_W'(A_TX_BYT_HI)) sel = DATA_W'(tx_hi_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      rx_hi_q <= '0;
      tx_hi_q <= '0;
    end else if (rd_en_i) begin
      data_q <= sel;
      if (rd_addr_i == ADDR_W'(C_RX_BYT)) rx_hi_q <= cnt_i[C_RX_BYT][BYTE_W-1:32];
      if (rd_addr_i == ADDR_W'(C_TX_BYT)) tx_hi_q <= cnt_i[C_TX_BYT][BYTE_W-1:32];
    end
  end

  assign rd_data_o = data_q;
endmodule

// File: rtl/eth_stat_counters.sv
module eth_stat_counters
  import eth_stat_pkg::*;
#(
  parameter int FRAME_W = 32,
  parameter int BYTE_W  = 45,
  parameter int LEN_W   = 14
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clear_all_i,
  input  logic                 rx_valid_i,
  input  logic [LEN_W-1:0]     rx_len_i,
  input  logic [1:0]           rx_cls_i,
  input  logic [N_RX_FLAG-1:0] rx_flags_i,
  input  logic                 rx_fifo_empty_i,
  input  logic                 tx_valid_i,
  input  logic [LEN_W-1:0]     tx_len_i,
  input  logic [1:0]           tx_cls_i,
  input  logic [N_TX_FLAG-1:0] tx_flags_i,
  input  logic                 rd_en_i,
  input  logic [ADDR_W-1:0]    rd_addr_i,
  output logic [DATA_W-1:0]    rd_data_o
);
  localparam int MAXSZ_W = FRAME_W - 1;

  logic [NCNT-1:0]              inc;
  logic [NCNT-1:0]              clr;
  logic [NCNT-1:0][BYTE_W-1:0]  cnt;

  stat_evt_dec #(.LEN_W(LEN_W)) u_dec (
    .rx_valid_i (rx_valid_i),
    .rx_len_i   (rx_len_i),
    .rx_cls_i   (rx_cls_i),
    .rx_flags_i (rx_flags_i),
    .tx_valid_i (tx_valid_i),
    .tx_len_i   (tx_len_i),
    .tx_cls_i   (tx_cls_i),
    .tx_flags_i (tx_flags_i),
    .inc_o      (inc)
  );

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    assign clr[i] = clear_all_i | (rd_en_i && rd_addr_i == ADDR_W'(i));
    if (i == C_RX_BYT || i == C_TX_BYT) begin : g_byte
      logic [BYTE_W-1:0] v;
      stat_sat_cnt #(.W(BYTE_W), .AW(LEN_W)) u_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .inc_i  (inc[i]),
        .clr_i  (clr[i]),
        .amt_i  ((i == C_RX_BYT) ? rx_len_i : tx_len_i),
        .val_o  (v)
      );
      assign cnt[i] = v;
    end else begin : g_frm
      localparam int W = (i == C_RX_MAXSZ) ? MAXSZ_W : FRAME_W;
      logic [W-1:0] v;
      stat_sat_cnt #(.W(W), .AW(1)) u_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .inc_i  (inc[i]),
        .clr_i  (clr[i]),
        .amt_i  (1'b1),
        .val_o  (v)
      );
      assign cnt[i] = BYTE_W'(v);
    end
  end

  stat_rd_port #(.BYTE_W(BYTE_W)) u_rd (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .rd_en_i         (rd_en_i),
    .rd_addr_i       (rd_addr_i),
    .rx_fifo_empty_i (rx_fifo_empty_i),
    .cnt_i           (cnt),
    .rd_data_o       (rd_data_o)
  );
endmodule

// File: rtl/eth_stat_counters_chk.sv
module eth_stat_counters_chk
  import eth_stat_pkg::*;
#(
  parameter int FRAME_W = 32,
  parameter int BYTE_W  = 45
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         clear_all_i,
  input logic                         rx_valid_i,
  input logic                         rx_fifo_empty_i,
  input logic                         tx_valid_i,
  input logic                         rd_en_i,
  input logic [ADDR_W-1:0]            rd_addr_i,
  input logic [DATA_W-1:0]            rd_data_o,
  input logic [NCNT-1:0]              inc_i,
  input logic [NCNT-1:0][BYTE_W-1:0]  cnt_i
);
  localparam logic [BYTE_W-1:0] FMAX = BYTE_W'({FRAME_W{1'b1}});

  logic rd_rx_frm, rd_tx_frm;
  assign rd_rx_frm = rd_en_i && rd_addr_i == ADDR_W'(C_RX_FRM);
  assign rd_tx_frm = rd_en_i && rd_addr_i == ADDR_W'(C_TX_FRM);

  a_r4_clear_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_all_i && !rx_valid_i && !tx_valid_i |=> cnt_i == '0);

  a_r12_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_all_i && !rd_rx_frm |=> cnt_i[C_RX_FRM] >= $past(cnt_i[C_RX_FRM]));

  a_r5_frame_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && !clear_all_i && !rd_rx_frm && cnt_i[C_RX_FRM] < FMAX
    |=> cnt_i[C_RX_FRM] == $past(cnt_i[C_RX_FRM]) + 1'b1);

  a_r3_keep_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_tx_frm && tx_valid_i |=> cnt_i[C_TX_FRM] == BYTE_W'(1));

  a_r9_one_bucket: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(inc_i[C_RX_BKT +: NBKT]) == (rx_valid_i ? 1 : 0));

  a_r10_empty_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && rd_addr_i == ADDR_W'(C_RX_MAXSZ) |=> rd_data_o[31] == $past(rx_fifo_empty_i));

  a_r13_unmapped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && rd_addr_i > ADDR_W'(A_TX_BYT_HI) |=> rd_data_o == '0);
endmodule

bind eth_stat_counters eth_stat_counters_chk #(.FRAME_W(FRAME_W), .BYTE_W(BYTE_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .clear_all_i     (clear_all_i),
  .rx_valid_i      (rx_valid_i),
  .rx_fifo_empty_i (rx_fifo_empty_i),
  .tx_valid_i      (tx_valid_i),
  .rd_en_i         (rd_en_i),
  .rd_addr_i       (rd_addr_i),
  .rd_data_o       (rd_data_o),
  .inc_i           (inc),
  .cnt_i           (cnt)
);

// File: tb/eth_stat_counters_bench.sv
`timescale 1ns/1ps
module eth_stat_counters_bench;
  import eth_stat_pkg::*;

  localparam int FRAME_W = 8;
  localparam int BYTE_W  = 34;
  localparam int LEN_W   = 20;
  localparam int NVEC    = 14;
  localparam logic [LEN_W-1:0] LMAX = '1;

  // {length, expected bucket}
  localparam logic [22:0] VEC [NVEC] = '{
    {20'd1, 3'd0},    {20'd64, 3'd0},   {20'd65, 3'd1},   {20'd127, 3'd1},
    {20'd128, 3'd2},  {20'd255, 3'd2},  {20'd256, 3'd3},  {20'd511, 3'd3},
    {20'd512, 3'd4},  {20'd1023, 3'd4}, {20'd1024, 3'd5}, {20'd1518, 3'd5},
    {20'd1519, 3'd6}, {20'd9000, 3'd6}
  };

  logic clk = 0, rst_n = 0;
  logic clear_all = 0, rx_valid = 0, tx_valid = 0, rx_empty = 0, rd_en = 0;
  logic [LEN_W-1:0] rx_len = '0, tx_len = '0;
  logic [1:0] rx_cls = '0, tx_cls = '0;
  logic [6:0] rx_flags = '0;
  logic [1:0] tx_flags = '0;
  logic [5:0] rd_addr = '0;
  logic [31:0] rd_data;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  eth_stat_counters #(.FRAME_W(FRAME_W), .BYTE_W(BYTE_W), .LEN_W(LEN_W)) u_eth_stat_counters (
    .clk_i(clk), .rst_ni(rst_n), .clear_all_i(clear_all),
    .rx_valid_i(rx_valid), .rx_len_i(rx_len), .rx_cls_i(rx_cls), .rx_flags_i(rx_flags),
    .rx_fifo_empty_i(rx_empty),
    .tx_valid_i(tx_valid), .tx_len_i(tx_len), .tx_cls_i(tx_cls), .tx_flags_i(tx_flags),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=0x%08h exp=0x%08h", req, got, exp);
    end
  endtask

  task automatic rd(input int addr, output logic [31:0] d);
    @(negedge clk); rd_en = 1; rd_addr = 6'(addr);
    @(negedge clk); rd_en = 0; d = rd_data;
  endtask

  task automatic rd_chk(input string req, input int addr, input logic [31:0] exp);
    logic [31:0] d;
    rd(addr, d);
    check(req, d, exp);
  endtask

  task automatic rx_burst(input logic [LEN_W-1:0] len, input logic [1:0] cls,
                          input logic [6:0] fl, input int n);
    @(negedge clk); rx_valid = 1; rx_len = len; rx_cls = cls; rx_flags = fl;
    repeat (n) @(negedge clk);
    rx_valid = 0; rx_flags = '0; rx_cls = '0;
  endtask

  task automatic tx_burst(input logic [LEN_W-1:0] len, input logic [1:0] cls,
                          input logic [1:0] fl, input int n);
    @(negedge clk); tx_valid = 1; tx_len = len; tx_cls = cls; tx_flags = fl;
    repeat (n) @(negedge clk);
    tx_valid = 0; tx_flags = '0; tx_cls = '0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd_chk("R1 rx frames", C_RX_FRM, 0);
    rd_chk("R1 tx bytes", C_TX_BYT, 0);
    rd_chk("R1 max-size", C_RX_MAXSZ, 0);

    // R9 R5 R2 table walk: one event per direction, then read its bucket and bytes
    for (int v = 0; v < NVEC; v++) begin
      rx_burst(VEC[v][22:3], 2'b00, 7'h00, 1);
      tx_burst(VEC[v][22:3], 2'b00, 2'b00, 1);
      rd_chk("R9 rx bucket", C_RX_BKT + int'(VEC[v][2:0]), 1);
      rd_chk("R9 tx bucket", C_TX_BKT + int'(VEC[v][2:0]), 1);
      rd_chk("R5 rx bytes", C_RX_BYT, 32'(VEC[v][22:3]));
      rd_chk("R5 tx bytes", C_TX_BYT, 32'(VEC[v][22:3]));
    end
    rd_chk("R3 bucket cleared by read", C_TX_BKT + 6, 0);
    rd_chk("R5 rx frames", C_RX_FRM, NVEC);
    rd_chk("R5 tx frames", C_TX_FRM, NVEC);
    rd_chk("R3 frames cleared", C_RX_FRM, 0);

    // R6 address class
    rx_burst(20'd100, 2'b01, 7'h00, 1);
    rx_burst(20'd100, 2'b10, 7'h00, 2);
    rx_burst(20'd100, 2'b11, 7'h00, 1);
    tx_burst(20'd100, 2'b01, 2'b00, 3);
    tx_burst(20'd100, 2'b00, 2'b00, 1);
    rd_chk("R6 rx multicast", C_RX_MC, 1);
    rd_chk("R6 rx broadcast", C_RX_BC, 2);
    rd_chk("R6 tx multicast", C_TX_MC, 3);
    rd_chk("R6 tx broadcast", C_TX_BC, 0);

    // R7 R8 flags
    rx_burst(20'd100, 2'b00, 7'h7f, 1);
    rx_burst(20'd100, 2'b00, 7'h02, 1);
    tx_burst(20'd100, 2'b00, 2'b11, 1);
    tx_burst(20'd100, 2'b00, 2'b10, 1);
    for (int b = 0; b < 6; b++) rd_chk("R7 rx flag counter", C_RX_FLAG + b, (b == 1) ? 2 : 1);
    rd_chk("R10 max-size count, fifo not empty", C_RX_MAXSZ, 32'h0000_0001);
    rd_chk("R8 tx pause", C_TX_FLAG, 1);
    rd_chk("R8 tx bad", C_TX_FLAG + 1, 2);

    // R10 empty flag in bit 31
    rx_burst(20'd100, 2'b00, 7'h40, 2);
    rx_empty = 1;
    rd_chk("R10 max-size with fifo empty", C_RX_MAXSZ, 32'h8000_0002);
    rd_chk("R10 flag only after clear", C_RX_MAXSZ, 32'h8000_0000);
    rx_empty = 0;

    // R11 wide byte counter
    rd(C_RX_BYT, d);
    rd(C_RX_FRM, d);
    rx_burst(LMAX, 2'b00, 7'h00, 4100);
    rd_chk("R11 rx bytes low", C_RX_BYT, 32'd4190204);
    rd_chk("R11 rx bytes high", A_RX_BYT_HI, 1);
    rd_chk("R11 high read does not clear", A_RX_BYT_HI, 1);
    rd_chk("R11 low cleared", C_RX_BYT, 0);
    rd_chk("R11 high relatched", A_RX_BYT_HI, 0);
    rd_chk("R12 frame counter saturates", C_RX_FRM, 32'd255);

    // R12 byte counter saturation
    rx_burst(LMAX, 2'b00, 7'h00, 16400);
    rd_chk("R12 bytes low saturated", C_RX_BYT, 32'hFFFF_FFFF);
    rd_chk("R12 bytes high saturated", A_RX_BYT_HI, 3);

    // R3 read colliding with increment
    rd(C_TX_FRM, d);
    tx_burst(20'd80, 2'b00, 2'b00, 3);
    @(negedge clk); tx_valid = 1; rd_en = 1; rd_addr = 6'(C_TX_FRM);
    @(negedge clk); tx_valid = 0; rd_en = 0;
    check("R3 read value before collision", rd_data, 3);
    rd_chk("R3 colliding event kept", C_TX_FRM, 1);

    // R4 global clear, alone and with a colliding event
    tx_burst(20'd80, 2'b00, 2'b00, 2);
    @(negedge clk); clear_all = 1;
    @(negedge clk); clear_all = 0;
    rd_chk("R4 tx bytes cleared", C_TX_BYT, 0);
    rd_chk("R4 tx frames cleared", C_TX_FRM, 0);
    tx_burst(20'd80, 2'b00, 2'b00, 1);
    @(negedge clk); clear_all = 1; rx_valid = 1; rx_len = 20'd100;
    @(negedge clk); clear_all = 0; rx_valid = 0;
    rd_chk("R4 event with clear counted", C_RX_FRM, 1);
    rd_chk("R4 event bytes with clear", C_RX_BYT, 100);
    rd_chk("R4 tx bytes cleared again", C_TX_BYT, 0);

    // R13 unmapped addresses
    rx_burst(20'd100, 2'b00, 7'h00, 1);
    rd_chk("R13 address 40 reads zero", 40, 0);
    rd_chk("R13 address 31 reads zero", 31, 0);
    rd_chk("R13 unmapped read cleared nothing", C_RX_FRM, 1);

    // R2 output holds between reads
    rx_burst(20'd100, 2'b00, 7'h00, 1);
    rd_chk("R2 read", C_RX_FRM, 1);
    repeat (3) @(negedge clk);
    check("R2 hold", rd_data, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule